// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block is the host-side register and command engine of a PC-style keyboard and mouse controller. The host reaches it over a byte-wide write bus. One select bit chooses between the command port and the data port. A command byte is decoded in the cycle it arrives. The block either acts on it at once, or it records the command as pending, so that the next data-port byte is sent to the right target. That target can be the mode register, the output port, the keyboard or mouse reply queue, or the mouse device.

The block holds the mode, status and output-port registers and exposes them as outputs. It drives the A20 gate from output-port bit 1 and issues a one-cycle system-reset request. Bytes that the controller must return to the host are sent as one-cycle reply strobes with a channel select, to a queue further down the chain. Raw bytes meant for the keyboard or mouse device are sent as one-cycle forward strobes. Every strobe and register update appears on the clock edge that accepts the host write.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the mode register reads 0x03, status reads 0x18, the output port reads 0x03, A20 is high, and no reply, forward or reset strobe is active.
- R2: Command 0x20 emits a keyboard-channel reply (reply_aux_o = 0) carrying the mode byte. Command 0xD0 does the same with the output-port byte.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only record a pending command. The next data-port byte then does one of the following: it is written to the mode register (0x60), it is written to the output port (0xD1), it is replied on the keyboard channel (0xD2), it is replied on the mouse channel with reply_aux_o = 1 (0xD3), or it is forwarded to the mouse with fwd_mouse_o = 1 (0xD4).
- R4: A data-port byte with no command pending is forwarded to the keyboard (fwd_mouse_o = 0). Every data-port write clears the pending command.
- R5: Command 0xAA sets status bit 2, which then stays set, and replies 0x55. Commands 0xA9, 0xAB and 0xC0 each reply 0x00.
- R6: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R7: Command 0xDF sets output-port bit 1 and A20. Command 0xDD clears both.
- R8: A command in 0xF0 to 0xFF with bit 0 low gives a single-cycle system-reset request. With bit 0 high it has no effect.
- R9: A write to the output port sets A20 from bit 1 of the byte. If bit 0 of the byte is low, it also requests a single-cycle system reset.
- R10: The scan-code translation enable output follows mode bit 6.
- R11: An unrecognized command changes no register, leaves any pending command as it was, and produces no strobe.
- R12: Each reply, forward or reset request is a strobe that lasts exactly one cycle per accepted host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | 1 = command port, 0 = data port |
| host_wdata | input | 8 | Host write byte |
| mode_o | output | 8 | Mode register |
| status_o | output | 8 | Status register |
| outport_o | output | 8 | Output-port register |
| a20_o | output | 1 | A20 gate |
| xlate_en_o | output | 1 | Scan-code translation enable (mode bit 6) |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| reply_vld_o | output | 1 | Reply byte strobe |
| reply_data_o | output | 8 | Reply byte |
| reply_aux_o | output | 1 | Reply channel: 0 keyboard, 1 mouse |
| fwd_vld_o | output | 1 | Forward-to-device strobe |
| fwd_data_o | output | 8 | Forwarded byte |
| fwd_mouse_o | output | 1 | Forward target: 0 keyboard, 1 mouse |

## Verification
The hardest case to reach is a pending two-byte command that survives other command traffic. An unrecognized command arrives between the prefix and its data byte, and the data byte must still go to the recorded target. Only after that may the target fall back to the keyboard. The stimulus sends 0x60, then unknown command bytes, then a data byte, and checks that the mode register took the byte. The output-port path is also driven with a byte whose reset bit is low, which proves the reset request is a single-cycle pulse that only a write can cause.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int unsigned BW = 8;

  typedef enum logic [2:0] {
    PND_NONE  = 3'd0,
    PND_MODE  = 3'd1,
    PND_OUTP  = 3'd2,
    PND_KQUE  = 3'd3,
    PND_AQUE  = 3'd4,
    PND_MOUSE = 3'd5
  } pend_e;

  typedef enum logic [1:0] {
    RSRC_CONST = 2'd0,
    RSRC_MODE  = 2'd1,
    RSRC_OUTP  = 2'd2
  } rsrc_e;

  typedef struct packed {
    logic          known;
    logic          reply_en;
    rsrc_e         reply_src;
    logic [BW-1:0] reply_const;
    logic          pend_en;
    pend_e         pend_val;
    logic [BW-1:0] mode_set;
    logic [BW-1:0] mode_clr;
    logic          selftest;
    logic          a20_set;
    logic          a20_clr;
    logic          rst_req;
  } cmd_act_t;

  localparam int unsigned MODE_MDIS_BIT  = 5;
  localparam int unsigned MODE_KDIS_BIT  = 4;
  localparam int unsigned MODE_XLATE_BIT = 6;
  localparam int unsigned STAT_TEST_BIT  = 2;
  localparam int unsigned OUTP_RST_BIT   = 0;
  localparam int unsigned OUTP_A20_BIT   = 1;

endpackage

// File: rtl/kbc_decode.sv
module kbc_decode
  import kbc_pkg::*;
(
  input  logic [BW-1:0] cmd_byte,
  output cmd_act_t      act
);

  always_comb begin
    act             = '0;
    act.reply_src   = RSRC_CONST;
    act.pend_val    = PND_NONE;
    if (cmd_byte[7:4] == 4'hF) begin
      act.known   = 1'b1;
      act.rst_req = ~cmd_byte[0];
    end else begin
      unique case (cmd_byte)
        8'h20: begin act.known = 1'b1; act.reply_en = 1'b1; act.reply_src = RSRC_MODE; end
        8'hD0: begin act.known = 1'b1; act.reply_en = 1'b1; act.reply_src = RSRC_OUTP; end
        8'h60: begin act.known = 1'b1; act.pend_en = 1'b1; act.pend_val = PND_MODE;  end
        8'hD1: begin act.known = 1'b1; act.pend_en = 1'b1; act.pend_val = PND_OUTP;  end
        8'hD2: begin act.known = 1'b1; act.pend_en = 1'b1; act.pend_val = PND_KQUE;  end
        8'hD3: begin act.known = 1'b1; act.pend_en = 1'b1; act.pend_val = PND_AQUE;  end
        8'hD4: begin act.known = 1'b1; act.pend_en = 1'b1; act.pend_val = PND_MOUSE; end
        8'hAA: begin
          act.known       = 1'b1;
          act.selftest    = 1'b1;
          act.reply_en    = 1'b1;
          act.reply_const = 8'h55;
        end
        8'hA9, 8'hAB, 8'hC0: begin
          act.known    = 1'b1;
          act.reply_en = 1'b1;
        end
        8'hA7: begin act.known = 1'b1; act.mode_set[MODE_MDIS_BIT] = 1'b1; end
        8'hA8: begin act.known = 1'b1; act.mode_clr[MODE_MDIS_BIT] = 1'b1; end
        8'hAD: begin act.known = 1'b1; act.mode_set[MODE_KDIS_BIT] = 1'b1; end
        8'hAE: begin act.known = 1'b1; act.mode_clr[MODE_KDIS_BIT] = 1'b1; end
        8'hDF: begin act.known = 1'b1; act.a20_set = 1'b1; end
        8'hDD: begin act.known = 1'b1; act.a20_clr = 1'b1; end
        default: act.known = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/kbc_pend.sv
module kbc_pend
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  pend_e set_val,
  input  logic  clr_en,
  output pend_e pend_q
);

  pend_e pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_en)      pend_d = PND_NONE;
    else if (set_en) pend_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= PND_NONE;
    else        pend_q <= pend_d;
  end

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_en) |-> (pend_q == PND_NONE)); // R4

endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] MODE_RST = 8'h03,
  parameter logic [BW-1:0] STAT_RST = 8'h18,
  parameter logic [BW-1:0] OUTP_RST = 8'h03
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  cmd_act_t      act,
  input  logic          mode_we,
  input  logic          outp_we,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] mode_q,
  output logic [BW-1:0] stat_q,
  output logic [BW-1:0] outp_q
);

  logic [BW-1:0] mode_d, stat_d, outp_d;
  logic          mode_ce, stat_ce, outp_ce;

  always_comb begin
    mode_d  = mode_q;
    stat_d  = stat_q;
    outp_d  = outp_q;
    mode_ce = 1'b0;
    stat_ce = 1'b0;
    outp_ce = 1'b0;
    if (cmd_en) begin
      if (|act.mode_set || |act.mode_clr) begin
        mode_ce = 1'b1;
        mode_d  = (mode_q | act.mode_set) & ~act.mode_clr;
      end
      if (act.selftest) begin
        stat_ce                = 1'b1;
        stat_d[STAT_TEST_BIT]  = 1'b1;
      end
      if (act.a20_set || act.a20_clr) begin
        outp_ce               = 1'b1;
        outp_d[OUTP_A20_BIT]  = act.a20_set;
      end
    end
    if (mode_we) begin
      mode_ce = 1'b1;
      mode_d  = wdata;
    end
    if (outp_we) begin
      outp_ce = 1'b1;
      outp_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      stat_q <= STAT_RST;
      outp_q <= OUTP_RST;
    end else begin
      if (mode_ce) mode_q <= mode_d;
      if (stat_ce) stat_q <= stat_d;
      if (outp_ce) outp_q <= outp_d;
    end
  end

  AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_q[STAT_TEST_BIT]) |-> stat_q[STAT_TEST_BIT]); // R5

  AST_MODE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(cmd_en || mode_we)); // R6

endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] mode_o,
  output logic [7:0] status_o,
  output logic [7:0] outport_o,
  output logic       a20_o,
  output logic       xlate_en_o,
  output logic       sys_rst_req_o,
  output logic       reply_vld_o,
  output logic [7:0] reply_data_o,
  output logic       reply_aux_o,
  output logic       fwd_vld_o,
  output logic [7:0] fwd_data_o,
  output logic       fwd_mouse_o
);

  cmd_act_t act;
  pend_e    pend_q;
  logic     cmd_we, dat_we;
  logic     mode_we, outp_we;

  logic          rep_vld_d, rep_aux_d, fwd_vld_d, fwd_mouse_d, rst_d;
  logic [BW-1:0] rep_data_d, fwd_data_d;

  assign cmd_we = host_wr &  host_sel;
  assign dat_we = host_wr & ~host_sel;

  kbc_decode u_dec (
    .cmd_byte (host_wdata),
    .act      (act)
  );

  kbc_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (cmd_we & act.pend_en),
    .set_val (act.pend_val),
    .clr_en  (dat_we),
    .pend_q  (pend_q)
  );

  kbc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_en  (cmd_we),
    .act     (act),
    .mode_we (mode_we),
    .outp_we (outp_we),
    .wdata   (host_wdata),
    .mode_q  (mode_o),
    .stat_q  (status_o),
    .outp_q  (outport_o)
  );

  assign a20_o      = outport_o[OUTP_A20_BIT];
  assign xlate_en_o = mode_o[MODE_XLATE_BIT];

  always_comb begin
    mode_we     = 1'b0;
    outp_we     = 1'b0;
    rep_vld_d   = 1'b0;
    rep_aux_d   = 1'b0;
    rep_data_d  = reply_data_o;
    fwd_vld_d   = 1'b0;
    fwd_mouse_d = fwd_mouse_o;
    fwd_data_d  = fwd_data_o;
    rst_d       = 1'b0;
    if (cmd_we) begin
      rst_d = act.rst_req;
      if (act.reply_en) begin
        rep_vld_d = 1'b1;
        unique case (act.reply_src)
          RSRC_MODE: rep_data_d = mode_o;
          RSRC_OUTP: rep_data_d = outport_o;
          default:   rep_data_d = act.reply_const;
        endcase
      end
    end else if (dat_we) begin
      unique case (pend_q)
        PND_MODE: mode_we = 1'b1;
        PND_OUTP: begin
          outp_we = 1'b1;
          rst_d   = ~host_wdata[OUTP_RST_BIT];
        end
        PND_KQUE, PND_AQUE: begin
          rep_vld_d  = 1'b1;
          rep_aux_d  = (pend_q == PND_AQUE);
          rep_data_d = host_wdata;
        end
        default: begin
          fwd_vld_d   = 1'b1;
          fwd_mouse_d = (pend_q == PND_MOUSE);
          fwd_data_d  = host_wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req_o <= 1'b0;
      reply_vld_o   <= 1'b0;
      reply_aux_o   <= 1'b0;
      reply_data_o  <= '0;
      fwd_vld_o     <= 1'b0;
      fwd_mouse_o   <= 1'b0;
      fwd_data_o    <= '0;
    end else begin
      sys_rst_req_o <= rst_d;
      reply_vld_o   <= rep_vld_d;
      fwd_vld_o     <= fwd_vld_d;
      if (rep_vld_d) begin
        reply_aux_o  <= rep_aux_d;
        reply_data_o <= rep_data_d;
      end
      if (fwd_vld_d) begin
        fwd_mouse_o <= fwd_mouse_d;
        fwd_data_o  <= fwd_data_d;
      end
    end
  end

  AST_RST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> $past(host_wr)); // R8

  AST_REPLY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_vld_o |-> $past(host_wr)); // R12

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reply_vld_o, fwd_vld_o, sys_rst_req_o}) <= 1); // R12

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_we && !act.known) |-> ($stable(mode_o) && $stable(outport_o)
                                     && !reply_vld_o && !sys_rst_req_o)); // R11

  AST_A20_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_o) |-> $past(host_wr)); // R7

endmodule

// File: tb/kbc_cmd_proc_tb.sv
module kbc_cmd_proc_tb;

  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic       host_sel;
  logic [7:0] host_wdata;
  logic [7:0] mode_o, status_o, outport_o;
  logic       a20_o, xlate_en_o, sys_rst_req_o;
  logic       reply_vld_o, reply_aux_o, fwd_vld_o, fwd_mouse_o;
  logic [7:0] reply_data_o, fwd_data_o;

  int n_chk;
  int n_fail;
  int exp_q[$];
  logic done;

  kbc_cmd_proc u_dut (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_sel (host_sel),
    .host_wdata (host_wdata), .mode_o (mode_o), .status_o (status_o),
    .outport_o (outport_o), .a20_o (a20_o), .xlate_en_o (xlate_en_o),
    .sys_rst_req_o (sys_rst_req_o), .reply_vld_o (reply_vld_o),
    .reply_data_o (reply_data_o), .reply_aux_o (reply_aux_o),
    .fwd_vld_o (fwd_vld_o), .fwd_data_o (fwd_data_o), .fwd_mouse_o (fwd_mouse_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // event code: kind<<16 | channel<<8 | data; kind 1 reply, 2 forward, 3 reset
  function automatic int ev(int kind, int ch, int data);
    return (kind << 16) | (ch << 8) | data;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d, int expect_ev = -1);
    if (expect_ev >= 0) exp_q.push_back(expect_ev);
    wr(1'b1, d);
  endtask

  task automatic dat(logic [7:0] d, int expect_ev = -1);
    if (expect_ev >= 0) exp_q.push_back(expect_ev);
    wr(1'b0, d);
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int got;
      int n;
      n = 0;
      got = 0;
      if (reply_vld_o)   begin n++; got = ev(1, int'(reply_aux_o), int'(reply_data_o)); end
      if (fwd_vld_o)     begin n++; got = ev(2, int'(fwd_mouse_o), int'(fwd_data_o)); end
      if (sys_rst_req_o) begin n++; got = ev(3, 0, 0); end
      if (n > 1) chk("R12 strobe count", n, 1);
      if (n > 0) begin
        if (exp_q.size() == 0) chk("R12 unexpected strobe", got, 0);
        else chk("R2-R9 strobe item", got, exp_q.pop_front());
      end
    end
  end

  initial begin
    done = 1'b0;
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 8'h03);
    chk("R1 status", status_o, 8'h18);
    chk("R1 outport", outport_o, 8'h03);
    chk("R1 a20", a20_o, 1);
    chk("R1 strobes", {reply_vld_o, fwd_vld_o, sys_rst_req_o}, 0);
    // R2 read-back replies
    cmd(8'h20, ev(1, 0, 8'h03));
    cmd(8'hD0, ev(1, 0, 8'h03));
    // R6 enable/disable bits
    cmd(8'hA7); chk("R6 mouse disable", mode_o, 8'h23);
    cmd(8'hA8); chk("R6 mouse enable", mode_o, 8'h03);
    cmd(8'hAD); chk("R6 kbd disable", mode_o, 8'h13);
    cmd(8'h20, ev(1, 0, 8'h13));
    cmd(8'hAE); chk("R6 kbd enable", mode_o, 8'h03);
    // R5 tests
    cmd(8'hAA, ev(1, 0, 8'h55)); chk("R5 self-test bit", status_o, 8'h1C);
    cmd(8'hA9, ev(1, 0, 8'h00));
    cmd(8'hAB, ev(1, 0, 8'h00));
    cmd(8'hC0, ev(1, 0, 8'h00));
    chk("R5 status sticky", status_o, 8'h1C);
    // R7 A20 commands
    cmd(8'hDD); chk("R7 outport a20 off", outport_o, 8'h01); chk("R7 a20 low", a20_o, 0);
    cmd(8'hD0, ev(1, 0, 8'h01));
    cmd(8'hDF); chk("R7 outport a20 on", outport_o, 8'h03); chk("R7 a20 high", a20_o, 1);
    // R8 pulse commands
    cmd(8'hF0, ev(3, 0, 0));
    cmd(8'hFE, ev(3, 0, 0));
    cmd(8'hFF); cmd(8'hF1);
    chk("R8 no-op pulse keeps outport", outport_o, 8'h03);
    // R9 output port writes
    cmd(8'hD1); dat(8'h01);
    chk("R9 outport", outport_o, 8'h01); chk("R9 a20 from bit1", a20_o, 0);
    cmd(8'hD1); dat(8'h02, ev(3, 0, 0));
    chk("R9 outport reset bit low", outport_o, 8'h02); chk("R9 a20 high", a20_o, 1);
    cmd(8'hD1); dat(8'h03);
    // R3 / R10 mode write and translation enable
    cmd(8'h60); dat(8'h43);
    chk("R3 mode write", mode_o, 8'h43); chk("R10 xlate on", xlate_en_o, 1);
    cmd(8'h60); dat(8'h03);
    chk("R10 xlate off", xlate_en_o, 0);
    // R3 queue and forward paths
    cmd(8'hD2); dat(8'h5A, ev(1, 0, 8'h5A));
    cmd(8'hD3); dat(8'h77, ev(1, 1, 8'h77));
    cmd(8'hD4); dat(8'hE8, ev(2, 1, 8'hE8));
    // R4 default keyboard path, pending cleared
    dat(8'h34, ev(2, 0, 8'h34));
    dat(8'h12, ev(2, 0, 8'h12));
    // R11 unknown commands, also while a prefix is pending
    cmd(8'h00); cmd(8'h55); cmd(8'hE0);
    chk("R11 mode unchanged", mode_o, 8'h03);
    chk("R11 status unchanged", status_o, 8'h1C);
    chk("R11 outport unchanged", outport_o, 8'h03);
    cmd(8'h60); cmd(8'h01); dat(8'h0B);
    chk("R11 pending survives unknown", mode_o, 8'h0B);
    dat(8'h66, ev(2, 0, 8'h66));
    chk("R4 mode untouched after clear", mode_o, 8'h0B);
    repeat (4) @(negedge clk);
    chk("R12 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule